// File: doc/BRIEF.md
# SPI Master Serial Clock and Select Timing Generator

This block produces the serial clock and the chip-select timing of an SPI master from one 32-bit configuration word. The word holds three kinds of setting. The first is a coded pair of factors for the bit period. The second is a coded pair of factors for each of three delays: the lead-in from select to the first clock edge, the tail from the last clock edge to deselect, and the idle gap between deselect and the end of the frame. The third is the clock polarity, the clock phase and the frame length.

A one-cycle start strobe accepts the word and a keep-select request. The block then runs one frame and ends it with a single-cycle done pulse. While the clock runs it marks each edge on which a receiver should capture data (sample strobe) and each edge on which a transmitter should move to the next bit (shift strobe). A shift register, a FIFO and a select decoder outside the block consume these strobes and the select enable.

Each length is the product of two factors picked from small fixed tables. Neither factor is a plain binary count.

Top module: `spi_tim_gen`

## Requirements
- R1: While reset is held and after it is released with no start, sck, sel_active, sample_stb, shift_stb and done are all 0.
- R2: The bit period D in system clocks is the baud prescaler factor times the baud scaler factor. The baud prescaler code sits in bits 17:16 and selects 2, 3, 5 or 7. The baud scaler code sits in bits 3:0: codes 0 to 3 select 2, 4, 6 or 8, and a code k of 4 or more selects 2^k. Consecutive leading SCK edges are D cycles apart.
- R3: Within each bit, SCK is high for floor(D/2) cycles and low for the remaining cycles.
- R4: sel_active is high in the first cycle after the accepting clock edge. The first SCK edge follows after Tlead + F cycles. Tlead = (2p+1)·2^(n+1), with p in bits 23:22 and n in bits 15:12. F is the first-half length of a bit: ceil(D/2) when CPOL = 0 and floor(D/2) when CPOL = 1.
- R5: sel_active falls Ttrail cycles after the final SCK edge, which returns the clock to idle. Ttrail = (2p+1)·2^(n+1), with p in bits 21:20 and n in bits 11:8.
- R6: done goes high Tgap cycles after sel_active falls, that is Ttrail + Tgap cycles after the final SCK edge. Tgap = (2p+1)·2^(n+1), with p in bits 19:18 and n in bits 7:4.
- R7: A frame has N leading SCK edges. N is the value in bits 30:27 plus one, and codes 0 to 2 give N = 4.
- R8: Outside the clocking interval, SCK rests at the CPOL level (bit 26) of the most recently accepted word.
- R9: With CPHA (bit 25) = 0, sample_stb is high on each of the N leading edges and shift_stb on each of the N-1 trailing edges that are not the last. With CPHA = 1, shift_stb is high on each of the N leading edges and sample_stb on each of the N trailing edges. The two strobes are never high together, and neither is high while select is inactive.
- R10: When keep_sel is high at start, sel_active stays high after the tail delay, through the gap and done and the idle cycles after them. It stays high until a later frame accepted with keep_sel low reaches the end of its tail delay.
- R11: The configuration word and keep_sel are captured only by a start in the idle state. A start, or a change of cfg_word, while a frame is running has no effect on that frame.
- R12: done is high for exactly one cycle per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Timing configuration word |
| start | input | 1 | Frame request, taken only when idle |
| keep_sel | input | 1 | Hold select asserted after the frame |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | Capture strobe, aligned with the SCK edge |
| shift_stb | output | 1 | Next-bit strobe, aligned with the SCK edge |
| sel_active | output | 1 | Chip-select enable |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle the assertions check the following. done never lasts two cycles, and the two strobes never overlap. No strobe and no SCK transition occurs without an active select. The latched word stays still while a frame is in flight. The number of leading edges never exceeds the frame length. At done, select equals the hold state. Only the bench's scenarios can show that the lengths are right: the exact cycle counts of the lead-in, bit period, high phase, tail and gap for every table code, the strobe totals for each CPOL/CPHA pair, the clamping of short frame codes, the keep-select chain, and the rejection of a start in mid-frame.

// File: rtl/spi_tim_pkg.sv
`timescale 1ns/1ps
package spi_tim_pkg;
  localparam int CFG_W    = 32;
  localparam int TIM_W    = 20;
  localparam int BIT_W    = 4;
  localparam int MIN_BITS = 4;

  typedef struct packed {
    logic       rsvd;
    logic [3:0] len_m1;
    logic       cpol;
    logic       cpha;
    logic       lsb_first;
    logic [1:0] lead_pre;
    logic [1:0] trail_pre;
    logic [1:0] gap_pre;
    logic [1:0] baud_pre;
    logic [3:0] lead_scl;
    logic [3:0] trail_scl;
    logic [3:0] gap_scl;
    logic [3:0] baud_scl;
  } tim_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL, ST_GAP, ST_DONE
  } tim_state_t;

  // baud prescaler: 2,3,5,7
  function automatic logic [TIM_W-1:0] baud_pre_factor(input logic [1:0] code);
    case (code)
      2'd0:    return TIM_W'(2);
      2'd1:    return TIM_W'(3);
      2'd2:    return TIM_W'(5);
      default: return TIM_W'(7);
    endcase
  endfunction

  // baud scaler: linear steps of two up to 8, then powers of two
  function automatic logic [TIM_W-1:0] baud_scl_factor(input logic [3:0] code);
    if (code < 4'd4) return TIM_W'((code + 4'd1) << 1);
    return TIM_W'(1) << code;
  endfunction

  // delay prescaler: odd numbers 1,3,5,7
  function automatic logic [TIM_W-1:0] dly_pre_factor(input logic [1:0] code);
    return TIM_W'({code, 1'b1});
  endfunction

  // delay scaler: 2^(code+1)
  function automatic logic [TIM_W-1:0] dly_scl_factor(input logic [3:0] code);
    return TIM_W'(1) << ({1'b0, code} + 5'd1);
  endfunction

  function automatic logic [TIM_W-1:0] scaled(input logic [TIM_W-1:0] a,
                                               input logic [TIM_W-1:0] b);
    return TIM_W'(a * b);
  endfunction
endpackage

// File: rtl/spi_tim_decode.sv
`timescale 1ns/1ps
module spi_tim_decode
  import spi_tim_pkg::*;
#(
  parameter int CNT_W  = TIM_W,
  parameter int BITS_W = BIT_W
) (
  input  tim_cfg_t          cfg,
  output logic [CNT_W-1:0]  bit_len,
  output logic [CNT_W-1:0]  first_seg,
  output logic [CNT_W-1:0]  lead_len,
  output logic [CNT_W-1:0]  trail_len,
  output logic [CNT_W-1:0]  gap_len,
  output logic [BITS_W-1:0] last_bit
);
  localparam logic [BITS_W-1:0] MIN_LAST = BITS_W'(MIN_BITS - 1);

  logic unused_fields;
  assign unused_fields = cfg.lsb_first ^ cfg.rsvd ^ cfg.cpha;

  assign bit_len   = CNT_W'(scaled(baud_pre_factor(cfg.baud_pre), baud_scl_factor(cfg.baud_scl)));
  assign lead_len  = CNT_W'(scaled(dly_pre_factor(cfg.lead_pre),  dly_scl_factor(cfg.lead_scl)));
  assign trail_len = CNT_W'(scaled(dly_pre_factor(cfg.trail_pre), dly_scl_factor(cfg.trail_scl)));
  assign gap_len   = CNT_W'(scaled(dly_pre_factor(cfg.gap_pre),   dly_scl_factor(cfg.gap_scl)));

  // high phase gets the floor half; the idle level fills the first segment
  assign first_seg = cfg.cpol ? (bit_len >> 1) : (bit_len - (bit_len >> 1));

  assign last_bit = (BITS_W'(cfg.len_m1) < MIN_LAST) ? MIN_LAST : BITS_W'(cfg.len_m1);
endmodule

// File: rtl/spi_tim_bitclk.sv
`timescale 1ns/1ps
module spi_tim_bitclk #(
  parameter int CNT_W  = spi_tim_pkg::TIM_W,
  parameter int BITS_W = spi_tim_pkg::BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  bit_len,
  input  logic [CNT_W-1:0]  first_seg,
  input  logic [BITS_W-1:0] last_bit,
  output logic              act_half,
  output logic              lead_evt,
  output logic              mid_trail_evt,
  output logic              frame_end
);
  logic [CNT_W-1:0]  phase;
  logic [BITS_W-1:0] bit_idx;
  logic              bit_end;

  assign bit_end = (phase == bit_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase   <= '0;
      bit_idx <= '0;
    end else if (bit_end) begin
      phase   <= '0;
      bit_idx <= bit_idx + BITS_W'(1);
    end else begin
      phase   <= phase + CNT_W'(1);
    end
  end

  assign act_half      = run && (phase >= first_seg);
  assign lead_evt      = run && (phase == first_seg);
  assign mid_trail_evt = run && (phase == '0) && (bit_idx != '0);
  assign frame_end     = run && bit_end && (bit_idx == last_bit);
endmodule

// File: rtl/spi_tim_seq.sv
`timescale 1ns/1ps
module spi_tim_seq
  import spi_tim_pkg::*;
#(
  parameter int CNT_W = TIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             keep_sel,
  input  logic [CNT_W-1:0] lead_len,
  input  logic [CNT_W-1:0] trail_len,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             frame_end,
  output logic             accept,
  output logic             busy,
  output logic             in_lead,
  output logic             in_xfer,
  output logic             in_trail,
  output logic             trail_first,
  output logic             sel_hold,
  output logic             done
);
  tim_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             keep_q;
  logic             xfer_q;

  assign accept = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      keep_q   <= 1'b0;
      sel_hold <= 1'b0;
      xfer_q   <= 1'b0;
    end else begin
      xfer_q <= (state == ST_XFER);
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_LEAD;
          cnt    <= '0;
          keep_q <= keep_sel;
        end
        ST_LEAD: if (cnt == lead_len - CNT_W'(1)) begin
          state <= ST_XFER;
          cnt   <= '0;
        end else cnt <= cnt + CNT_W'(1);
        ST_XFER: if (frame_end) begin
          state <= ST_TRAIL;
          cnt   <= '0;
        end
        ST_TRAIL: if (cnt == trail_len - CNT_W'(1)) begin
          state    <= ST_GAP;
          cnt      <= '0;
          sel_hold <= keep_q;
        end else cnt <= cnt + CNT_W'(1);
        ST_GAP: if (cnt == gap_len - CNT_W'(1)) begin
          state <= ST_DONE;
          cnt   <= '0;
        end else cnt <= cnt + CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign in_lead     = (state == ST_LEAD);
  assign in_xfer     = (state == ST_XFER);
  assign in_trail    = (state == ST_TRAIL);
  assign trail_first = in_trail && xfer_q;
  assign done        = (state == ST_DONE);
endmodule

// File: rtl/spi_tim_gen.sv
`timescale 1ns/1ps
module spi_tim_gen
  import spi_tim_pkg::*;
#(
  parameter int CNT_W  = TIM_W,
  parameter int BITS_W = BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             start,
  input  logic             keep_sel,
  output logic             sck,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             sel_active,
  output logic             done
);
  tim_cfg_t          cfg_q;
  logic [CNT_W-1:0]  bit_len, first_seg, lead_len, trail_len, gap_len;
  logic [BITS_W-1:0] last_bit;
  logic [BITS_W:0]   frame_bits;
  logic accept, busy, in_lead, in_xfer, in_trail, trail_first, sel_hold;
  logic act_half, lead_evt, mid_trail_evt, frame_end, trail_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= tim_cfg_t'(cfg_word);
  end

  spi_tim_decode #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_decode (
    .cfg(cfg_q), .bit_len(bit_len), .first_seg(first_seg), .lead_len(lead_len),
    .trail_len(trail_len), .gap_len(gap_len), .last_bit(last_bit)
  );

  spi_tim_bitclk #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(in_xfer), .bit_len(bit_len),
    .first_seg(first_seg), .last_bit(last_bit), .act_half(act_half),
    .lead_evt(lead_evt), .mid_trail_evt(mid_trail_evt), .frame_end(frame_end)
  );

  spi_tim_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .keep_sel(keep_sel),
    .lead_len(lead_len), .trail_len(trail_len), .gap_len(gap_len),
    .frame_end(frame_end), .accept(accept), .busy(busy), .in_lead(in_lead),
    .in_xfer(in_xfer), .in_trail(in_trail), .trail_first(trail_first),
    .sel_hold(sel_hold), .done(done)
  );

  assign frame_bits = {1'b0, last_bit} + (BITS_W+1)'(1);
  assign trail_evt  = mid_trail_evt || trail_first;

  assign sck        = cfg_q.cpol ^ act_half;
  assign sample_stb = cfg_q.cpha ? trail_evt : lead_evt;
  assign shift_stb  = cfg_q.cpha ? lead_evt  : mid_trail_evt;
  assign sel_active = in_lead || in_xfer || in_trail || sel_hold;
endmodule

// File: rtl/spi_tim_chk.sv
`timescale 1ns/1ps
module spi_tim_chk #(
  parameter int BITS_W = spi_tim_pkg::BIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              sample_stb,
  input logic              shift_stb,
  input logic              sel_active,
  input logic              done,
  input logic              busy,
  input logic              accept,
  input logic              sel_hold,
  input logic [31:0]       cfg_q,
  input logic [BITS_W:0]   frame_bits
);
  logic [BITS_W+1:0] lead_cnt;
  logic              sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_cnt <= '0;
      sck_q    <= 1'b0;
    end else begin
      sck_q <= sck;
      if (accept) lead_cnt <= '0;
      else if (sck != sck_q && sck != cfg_q[26]) lead_cnt <= lead_cnt + 1'b1;
    end
  end

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  assert_strobe_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> sel_active);

  assert_sck_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> sel_active);

  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  assert_deselect_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sel_active == sel_hold));

  assert_lead_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_cnt <= {1'b0, frame_bits});
endmodule

bind spi_tim_gen spi_tim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .sample_stb(sample_stb),
  .shift_stb(shift_stb), .sel_active(sel_active), .done(done), .busy(busy),
  .accept(accept), .sel_hold(sel_hold), .cfg_q(cfg_q), .frame_bits(frame_bits)
);

// File: tb/spi_tim_gen_test.sv
`timescale 1ns/1ps
module spi_tim_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        keep_sel = 1'b0;
  logic [31:0] cfg_word = '0;
  wire sck, sample_stb, shift_stb, sel_active, done;
  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  spi_tim_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .start(start),
    .keep_sel(keep_sel), .sck(sck), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .sel_active(sel_active), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bpre(input int c);
    int t[4] = '{2, 3, 5, 7};
    return t[c];
  endfunction

  function automatic int bscl(input int c);
    int v = 16;
    if (c < 4) return 2 * c + 2;
    for (int i = 4; i < c; i++) v = v * 2;
    return v;
  endfunction

  function automatic int dlen(input int p, input int n);
    return (1 + 2 * p) * (1 << (n + 1));
  endfunction

  function automatic logic [31:0] mk(input int len_m1, input int cpol, input int cpha,
      input int lp, input int ln, input int tp, input int tn,
      input int gp, input int gn, input int bp, input int bn);
    logic [31:0] w = '0;
    w[30:27] = 4'(len_m1); w[26] = 1'(cpol); w[25] = 1'(cpha);
    w[23:22] = 2'(lp); w[21:20] = 2'(tp); w[19:18] = 2'(gp); w[17:16] = 2'(bp);
    w[15:12] = 4'(ln); w[11:8] = 4'(tn); w[7:4] = 4'(gn); w[3:0] = 4'(bn);
    return w;
  endfunction

  task automatic run_frame(input logic [31:0] cfg, input bit keep, input bit inject);
    int d   = bpre(int'(cfg[17:16])) * bscl(int'(cfg[3:0]));
    int tl  = dlen(int'(cfg[23:22]), int'(cfg[15:12]));
    int tt  = dlen(int'(cfg[21:20]), int'(cfg[11:8]));
    int tg  = dlen(int'(cfg[19:18]), int'(cfg[7:4]));
    int n   = (int'(cfg[30:27]) + 1 < 4) ? 4 : int'(cfg[30:27]) + 1;
    int pol = int'(cfg[26]);
    int pha = int'(cfg[25]);
    int lf  = pol ? d / 2 : d - d / 2;
    int first_edge = -1, lead1 = -1, lead2 = -1, trail1 = -1, last_trail = -1;
    int sel_fall = -1, done_at = -1, leads = 0, samples = 0, shifts = 0;
    int lead_samp = 0, lead_shift = 0, hi_len;
    logic prev_sck;
    @(negedge clk);
    cfg_word = cfg; keep_sel = keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_sck = sck;
    for (int c = 0; c < 100000 && done_at < 0; c++) begin
      if (c > 0) @(negedge clk);
      if (inject && c == 3) begin cfg_word = ~cfg; keep_sel = ~keep; start = 1'b1; end
      if (inject && c == 4) start = 1'b0;
      if (c == 0) begin
        chk("R4 select up at first cycle", int'(sel_active), 1);
        chk("R8 idle level", int'(sck), pol);
      end else if (sck != prev_sck) begin
        if (first_edge < 0) first_edge = c;
        if (int'(sck) != pol) begin
          leads++;
          if (lead1 < 0) lead1 = c; else if (lead2 < 0) lead2 = c;
          if (sample_stb) lead_samp++;
          if (shift_stb) lead_shift++;
        end else begin
          if (trail1 < 0) trail1 = c;
          last_trail = c;
        end
      end
      if (sample_stb) samples++;
      if (shift_stb) shifts++;
      if (!sel_active && sel_fall < 0) sel_fall = c;
      if (done) done_at = c;
      prev_sck = sck;
    end
    if (done_at < 0) begin
      chk("R6 frame never finished", 0, 1);
      return;
    end
    chk("R4 lead-in to first edge", first_edge, tl + lf);
    chk("R2 bit period", lead2 - lead1, d);
    chk("R7 leading edge count", leads, n);
    hi_len = pol ? (lead2 - trail1) : (trail1 - lead1);
    chk("R3 high phase", hi_len, d / 2);
    chk("R2 clocking span", last_trail, tl + n * d);
    if (keep) chk("R10 select kept through frame end", sel_fall, -1);
    else      chk("R5 tail delay", sel_fall - last_trail, tt);
    chk("R6 gap to done", done_at, last_trail + tt + tg);
    if (pha == 0) begin
      chk("R9 cpha0 samples on leading", lead_samp, n);
      chk("R9 cpha0 sample total", samples, n);
      chk("R9 cpha0 shift total", shifts, n - 1);
    end else begin
      chk("R9 cpha1 shifts on leading", lead_shift, n);
      chk("R9 cpha1 shift total", shifts, n);
      chk("R9 cpha1 sample total", samples, n);
    end
    @(negedge clk);
    chk("R12 done one cycle", int'(done), 0);
    chk("R8 idle level after frame", int'(sck), pol);
    chk("R10 select after frame", int'(sel_active), int'(keep));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sck in reset", int'(sck), 0);
    chk("R1 select in reset", int'(sel_active), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 strobes after reset", int'(sample_stb) + int'(shift_stb), 0);
    chk("R1 select after reset", int'(sel_active), 0);

    // baud table sweep (R2, R3)
    for (int bp = 0; bp < 4; bp++)
      for (int bn = 0; bn < 5; bn++)
        run_frame(mk(3, (bp + bn) % 2, bn % 2, 0, 0, 0, 0, 0, 0, bp, bn), 1'b0, 1'b0);

    // delay table sweep (R4, R5, R6)
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++)
        run_frame(mk(4, p % 2, q % 2, p, q, (p + 1) % 4, q, p, (q + 2) % 4, 0, 0), 1'b0, 1'b0);

    // frame length sweep with all CPOL/CPHA pairs (R7, R8, R9)
    for (int l = 0; l < 16; l++)
      run_frame(mk(l, l % 2, (l / 2) % 2, 0, 1, 1, 0, 0, 0, 1, 0), 1'b0, 1'b0);

    // keep-select chain (R10)
    run_frame(mk(5, 0, 0, 1, 0, 0, 1, 0, 0, 0, 1), 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 select held while idle", int'(sel_active), 1);
    run_frame(mk(5, 1, 1, 1, 0, 0, 1, 0, 0, 0, 1), 1'b1, 1'b0);
    run_frame(mk(5, 0, 1, 0, 0, 2, 0, 0, 0, 0, 0), 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 select released", int'(sel_active), 0);

    // start and cfg change in mid-frame ignored (R11)
    run_frame(mk(6, 1, 0, 0, 1, 1, 1, 1, 0, 2, 1), 1'b0, 1'b1);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 no stray frame", int'(sel_active) + int'(done), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule